// File: doc/BRIEF.md
# Windowed I/O Port Bridge with Endian Lanes

This block converts processor load and store requests that land in an 8 MB memory-mapped window into single transactions on a narrow I/O port bus. The port number is derived from the processor address in one of two layouts. In the dense layout the port is simply the low 16 address bits. In the sparse layout the low five bits are kept and the page-number bits are folded down, so each group of 32 ports occupies its own 4 KB page. A separate input selects the layout.

When the big-endian input is set, the block reverses the byte lanes of half-word and word data on the way out and again on the way back. This lets a big-endian processor see I/O registers in their natural little-endian order. Byte data is never altered.

Only one request is in flight at a time. The processor side waits for a one-cycle ready pulse. A request whose address lies outside the window is answered at once with a miss flag and produces no I/O transaction.

Top module: `io_window_bridge`

## Requirements
- R1: After synchronous reset, cpu_ready, cpu_miss and io_valid are all low.
- R2: A request is a hit only when cpu_addr[31:23] equals 9'h100, which covers 0x80000000 to 0x807FFFFF. A miss raises io_valid never. On the clock edge after acceptance, it gives a one-cycle cpu_ready with cpu_miss=1 and cpu_rdata=0.
- R3: With map_sparse=0 the port address io_addr equals cpu_addr[15:0].
- R4: With map_sparse=1 the port address io_addr equals {cpu_addr[22:12], cpu_addr[4:0]}, which is (addr & 0x1F) | ((addr & 0x7FFF000) >> 7) cut to 16 bits.
- R5: Byte requests (cpu_size=2'd0) pass write data and read data through unchanged in both endian modes.
- R6: With big_endian=1, half-word requests (cpu_size=2'd1) exchange bits [7:0] and [15:8] on both the write and the read path, and leave bits [31:16] unchanged.
- R7: With big_endian=1, word requests (cpu_size=2'd2, and the reserved code 2'd3) fully reverse the four bytes in both directions. With big_endian=0 no size alters the data.
- R8: map_sparse and big_endian are captured when a request is accepted. Changing them while the transfer is in flight alters neither io_addr, nor io_wdata, nor the returned read data.
- R9: io_valid stays high, with its fields stable, until io_ready is seen. cpu_ready pulses for exactly one cycle, on the edge after the io_valid and io_ready handshake, with cpu_miss=0. cpu_ready stays low while the transfer waits.
- R10: io_size and io_we carry the accepted request's cpu_size and cpu_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| map_sparse | input | 1 | Port layout select: 0 dense, 1 sparse |
| big_endian | input | 1 | Enables lane reversal for half-word and word data |
| cpu_valid | input | 1 | Processor request present, held until cpu_ready |
| cpu_addr | input | 32 | Processor byte address |
| cpu_size | input | 2 | 0 byte, 1 half-word, 2 word |
| cpu_we | input | 1 | 1 for store, 0 for load |
| cpu_wdata | input | 32 | Store data, right-justified |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_miss | output | 1 | Completion was an out-of-window miss |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready |
| io_valid | output | 1 | I/O transaction request |
| io_ready | input | 1 | I/O side accepts and completes the transaction |
| io_addr | output | 16 | Port number |
| io_size | output | 2 | Transfer size |
| io_we | output | 1 | Transfer direction |
| io_wdata | output | 32 | Lane-adjusted store data |
| io_rdata | input | 32 | Load data from the port, sampled with io_ready |

## Verification
Two events can land in the same cycle: a mode change and a transfer that is still waiting for its handshake. The bench flips both map_sparse and big_endian during the wait window, including the cycle in which io_ready is raised. It then judges the port address held on the bus, and the lane order of the read data that comes back, against the modes that were in force when the request was accepted. A second overlap is the completion edge itself, where lane reversal of the returned data and the ready pulse occur together. Each read check samples cpu_rdata only in the cycle in which cpu_ready is high.

// File: rtl/iob_pkg.sv
package iob_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } bridge_state_e;
endpackage

// File: rtl/iob_addr_map.sv
module iob_addr_map #(
  parameter int          CPU_AW    = 32,
  parameter int          IO_AW     = 16,
  parameter int          WIN_LOG2  = 23,
  parameter logic [31:0] WIN_BASE  = 32'h8000_0000,
  parameter int          SPARSE_LO = 5,
  parameter int          PAGE_LSB  = 12
) (
  input  logic [CPU_AW-1:0] addr,
  input  logic              sparse,
  output logic              hit,
  output logic [IO_AW-1:0]  port
);
  localparam int TAG_W   = CPU_AW - WIN_LOG2;
  localparam int FOLD_W  = IO_AW - SPARSE_LO;
  localparam int FOLD_HI = PAGE_LSB + FOLD_W - 1;

  logic [TAG_W-1:0] win_tag;
  logic [IO_AW-1:0] dense_port;
  logic [IO_AW-1:0] sparse_port;

  assign win_tag     = WIN_BASE[CPU_AW-1:WIN_LOG2];
  assign hit         = (addr[CPU_AW-1:WIN_LOG2] == win_tag);
  assign dense_port  = addr[IO_AW-1:0];
  assign sparse_port = {addr[FOLD_HI:PAGE_LSB], addr[SPARSE_LO-1:0]};
  assign port        = sparse ? sparse_port : dense_port;
endmodule

// File: rtl/iob_lane_swap.sv
module iob_lane_swap
  import iob_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        size,
  input  logic              enable,
  output logic [DATA_W-1:0] dout
);
  localparam int NBYTES = DATA_W / 8;

  logic [DATA_W-1:0] full_rev;
  logic [DATA_W-1:0] half_rev;

  for (genvar b = 0; b < NBYTES; b++) begin : g_rev
    assign full_rev[8*b +: 8] = din[8*(NBYTES-1-b) +: 8];
  end

  assign half_rev = {din[DATA_W-1:16], din[7:0], din[15:8]};

  always_comb begin
    dout = din;
    if (enable) begin
      case (xfer_size_e'(size))
        SZ_BYTE: dout = din;
        SZ_HALF: dout = half_rev;
        default: dout = full_rev;
      endcase
    end
  end
endmodule

// File: rtl/io_window_bridge.sv
module io_window_bridge
  import iob_pkg::*;
#(
  parameter int          CPU_AW   = 32,
  parameter int          IO_AW    = 16,
  parameter int          DATA_W   = 32,
  parameter int          WIN_LOG2 = 23,
  parameter logic [31:0] WIN_BASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_sparse,
  input  logic              big_endian,
  input  logic              cpu_valid,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [1:0]        cpu_size,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_miss,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              io_valid,
  input  logic              io_ready,
  output logic [IO_AW-1:0]  io_addr,
  output logic [1:0]        io_size,
  output logic              io_we,
  output logic [DATA_W-1:0] io_wdata,
  input  logic [DATA_W-1:0] io_rdata
);
  bridge_state_e     state;
  logic              be_q;
  logic              win_hit;
  logic [IO_AW-1:0]  port_nxt;
  logic [DATA_W-1:0] wdata_sw;
  logic [DATA_W-1:0] rdata_sw;

  iob_addr_map #(
    .CPU_AW  (CPU_AW),
    .IO_AW   (IO_AW),
    .WIN_LOG2(WIN_LOG2),
    .WIN_BASE(WIN_BASE)
  ) u_map (
    .addr  (cpu_addr),
    .sparse(map_sparse),
    .hit   (win_hit),
    .port  (port_nxt)
  );

  iob_lane_swap #(.DATA_W(DATA_W)) u_wswap (
    .din   (cpu_wdata),
    .size  (cpu_size),
    .enable(big_endian),
    .dout  (wdata_sw)
  );

  iob_lane_swap #(.DATA_W(DATA_W)) u_rswap (
    .din   (io_rdata),
    .size  (io_size),
    .enable(be_q),
    .dout  (rdata_sw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      be_q      <= 1'b0;
      cpu_ready <= 1'b0;
      cpu_miss  <= 1'b0;
      cpu_rdata <= '0;
      io_valid  <= 1'b0;
      io_addr   <= '0;
      io_size   <= '0;
      io_we     <= 1'b0;
      io_wdata  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cpu_ready <= 1'b0;
          if (cpu_valid) begin
            if (win_hit) begin
              io_valid <= 1'b1;
              io_addr  <= port_nxt;
              io_size  <= cpu_size;
              io_we    <= cpu_we;
              io_wdata <= wdata_sw;
              be_q     <= big_endian;
              state    <= ST_WAIT;
            end else begin
              cpu_ready <= 1'b1;
              cpu_miss  <= 1'b1;
              cpu_rdata <= '0;
              state     <= ST_DONE;
            end
          end
        end
        ST_WAIT: begin
          if (io_ready) begin
            io_valid  <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_miss  <= 1'b0;
            cpu_rdata <= rdata_sw;
            state     <= ST_DONE;
          end
        end
        default: begin
          cpu_ready <= 1'b0;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cpu_ready && cpu_miss) |-> !io_valid); // R2

  AST_IO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (io_valid && !io_ready) |=> io_valid); // R9

  AST_IO_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (io_valid && !io_ready) |=> ($stable(io_addr) && $stable(io_wdata) && $stable(io_size))); // R8

  AST_DONE_AFTER_IO: assert property (@(posedge clk) disable iff (rst)
    (io_valid && io_ready) |=> (cpu_ready && !cpu_miss)); // R9

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R9

  AST_NO_READY_WHILE_WAIT: assert property (@(posedge clk) disable iff (rst)
    io_valid |-> !cpu_ready); // R9
endmodule

// File: tb/io_window_bridge_tb.sv
module io_window_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        map_sparse = 1'b0;
  logic        big_endian = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [1:0]  cpu_size = '0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_ready;
  logic        cpu_miss;
  logic [31:0] cpu_rdata;
  logic        io_valid;
  logic        io_ready = 1'b0;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic        io_we;
  logic [31:0] io_wdata;
  logic [31:0] io_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #5 clk = ~clk;

  io_window_bridge dut_i (
    .clk(clk), .rst(rst), .map_sparse(map_sparse), .big_endian(big_endian),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_miss(cpu_miss), .cpu_rdata(cpu_rdata), .io_valid(io_valid),
    .io_ready(io_ready), .io_addr(io_addr), .io_size(io_size), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", cycles, 0);
      finish_run();
    end
  end

  // Hit access: waits for io_valid, holds io_ready low for 'delay' cycles,
  // optionally flipping both mode inputs meanwhile, then completes.
  task automatic hit_access(input logic [31:0] addr, input logic [1:0] size, input bit we,
                            input logic [31:0] wdata, input logic [31:0] dev_rdata,
                            input int delay, input bit flip,
                            input logic [15:0] exp_port, input logic [31:0] exp_wdata,
                            input logic [31:0] exp_rdata, input string tag);
    int guard;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = addr; cpu_size = size; cpu_we = we; cpu_wdata = wdata;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!io_valid && !cpu_ready && guard < 20);
    check(io_valid === 1'b1, {tag, " R2 hit issues io_valid"}, {31'd0, io_valid}, 32'd1);
    check(io_addr === exp_port, {tag, " R3/R4 port"}, {16'd0, io_addr}, {16'd0, exp_port});
    check(io_wdata === exp_wdata, {tag, " R5/R6/R7 wdata"}, io_wdata, exp_wdata);
    check(io_size === size && io_we === we, {tag, " R10 size/we"}, {29'd0, io_size, io_we}, {29'd0, size, we});
    for (int i = 0; i < delay; i++) begin
      if (flip) begin map_sparse = ~map_sparse; big_endian = ~big_endian; end
      @(negedge clk);
      check(io_valid === 1'b1 && cpu_ready === 1'b0, {tag, " R9 hold while waiting"},
            {30'd0, io_valid, cpu_ready}, 32'd2);
      check(io_addr === exp_port, {tag, " R8 port frozen"}, {16'd0, io_addr}, {16'd0, exp_port});
    end
    if (flip) begin map_sparse = ~map_sparse; big_endian = ~big_endian; end
    io_ready = 1'b1; io_rdata = dev_rdata;
    @(negedge clk);
    io_ready = 1'b0; io_rdata = 32'hxxxx_xxxx;
    cpu_valid = 1'b0;
    check(cpu_ready === 1'b1 && cpu_miss === 1'b0 && io_valid === 1'b0, {tag, " R9 completion pulse"},
          {29'd0, cpu_ready, cpu_miss, io_valid}, 32'd4);
    check(cpu_rdata === exp_rdata, {tag, " R5/R6/R7/R8 rdata"}, cpu_rdata, exp_rdata);
    @(negedge clk);
    check(cpu_ready === 1'b0, {tag, " R9 pulse one cycle"}, {31'd0, cpu_ready}, 32'd0);
  endtask

  task automatic miss_access(input logic [31:0] addr, input string tag);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_addr = addr; cpu_size = 2'd2; cpu_we = 1'b0;
    @(negedge clk);
    cpu_valid = 1'b0;
    check(cpu_ready === 1'b1 && cpu_miss === 1'b1 && io_valid === 1'b0, {tag, " R2 miss response"},
          {29'd0, cpu_ready, cpu_miss, io_valid}, 32'd6);
    check(cpu_rdata === 32'd0, {tag, " R2 miss rdata"}, cpu_rdata, 32'd0);
    @(negedge clk);
    check(cpu_ready === 1'b0 && io_valid === 1'b0, {tag, " R2 miss quiet after"},
          {30'd0, cpu_ready, io_valid}, 32'd0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(cpu_ready === 1'b0 && cpu_miss === 1'b0 && io_valid === 1'b0, "R1 reset state",
          {29'd0, cpu_ready, cpu_miss, io_valid}, 32'd0);
  endtask

  task automatic t_dense_le();
    map_sparse = 1'b0; big_endian = 1'b0;
    hit_access(32'h8000_1234, 2'd0, 1'b1, 32'hCAFE_0055, 32'h0000_0077, 0, 1'b0,
               16'h1234, 32'hCAFE_0055, 32'h0000_0077, "dense byte LE");
    hit_access(32'h8000_ABC8, 2'd2, 1'b0, 32'h1122_3344, 32'h5566_7788, 1, 1'b0,
               16'hABC8, 32'h1122_3344, 32'h5566_7788, "dense word LE R7");
  endtask

  task automatic t_sparse();
    map_sparse = 1'b1; big_endian = 1'b0;
    hit_access(32'h8012_3456, 2'd1, 1'b1, 32'h0000_BEEF, 32'h0, 0, 1'b0,
               16'h2476, 32'h0000_BEEF, 32'h0, "sparse R4");
    hit_access(32'h807F_FFFF, 2'd0, 1'b0, 32'h0, 32'h0000_00A5, 0, 1'b0,
               16'hFFFF, 32'h0, 32'h0000_00A5, "sparse top edge R4");
  endtask

  task automatic t_endian();
    map_sparse = 1'b0; big_endian = 1'b1;
    hit_access(32'h8000_0010, 2'd1, 1'b1, 32'hAABB_1122, 32'hCCDD_3344, 0, 1'b0,
               16'h0010, 32'hAABB_2211, 32'hCCDD_4433, "BE half R6");
    hit_access(32'h8000_0020, 2'd2, 1'b1, 32'hDEAD_BEEF, 32'h1122_3344, 2, 1'b0,
               16'h0020, 32'hEFBE_ADDE, 32'h4433_2211, "BE word R7");
    hit_access(32'h8000_0030, 2'd0, 1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 0, 1'b0,
               16'h0030, 32'h1234_5678, 32'h9ABC_DEF0, "BE byte R5");
    hit_access(32'h8000_FFFF, 2'd1, 1'b0, 32'h0, 32'h0000_0102, 0, 1'b0,
               16'hFFFF, 32'h0, 32'h0000_0201, "dense top edge R3");
  endtask

  task automatic t_mode_change_in_flight();
    map_sparse = 1'b1; big_endian = 1'b1;
    hit_access(32'h8000_5003, 2'd2, 1'b0, 32'h0, 32'hA1B2_C3D4, 3, 1'b1,
               16'h00A3, 32'h0, 32'hD4C3_B2A1, "flip in flight R8");
  endtask

  task automatic t_miss();
    map_sparse = 1'b0; big_endian = 1'b0;
    miss_access(32'h8080_0000, "above window");
    miss_access(32'h7FFF_FFFF, "below window");
  endtask

  initial begin
    t_reset();
    t_dense_le();
    t_sparse();
    t_endian();
    t_mode_change_in_flight();
    t_miss();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule